// File: doc/BRIEF.md
# Rolling-Shutter Row Pulse Sequencer

This block is the controller-side timing generator that drives the row control lines of an area image sensor. It runs from a master clock. At the start of every row it plays out a fixed order of pulses: the row clock that advances the sensor's row pointers, column precharge, row select, the sample of the pixel signal level, deselect, the pixel reset, a second precharge and the sample of the reset level. The difference of the two samples gives correlated double sampling. Every pulse width and inter-pulse delay is given in master-clock cycles. The sequencer copies these values when a frame starts.

Two modes are supported. In full-frame mode only the read pointer drives the pixel reset line. In rolling-shutter mode a second reset pulse goes to the row held by a separate reset pointer, and two drive-select lines swap around that pulse. The reset pointer is started a programmed number of rows ahead of the read pointer, and that lead is the integration time. Active-low sync pulses bring each pointer back to the first row. A programmable number of leading rows can be blacked out as a dark reference. Per-row and per-frame strobes tell the downstream readout logic when a row or frame is finished. Frames follow one another without a gap for as long as `run` is held high.

Top module: `row_pulse_sequencer`

## Requirements
- R1: After reset, and whenever the block is idle, all pulse outputs and both drive-select lines are low and both sync outputs are high. While `run` is low the block stays idle.
- R2: `col_prechg` and `row_sel` are never high in the same cycle. `row_sel` rises exactly `cfg_gap` cycles after the cycle in which the first precharge ends.
- R3: Call the effective gap G, row-clock width C, precharge width P, sample width S and reset width Rw. A row then lasts these cycles, in this order: G idle, C with `row_clk` high, G, P with `col_prechg`, G, G with `row_sel`, S with `row_sel` and `samp_sig`, G with `row_sel`, G, Rw with `px_reset`, G, P with `col_prechg`, G, S with `samp_rst`, then one end cycle. A sample line high means hold and low means track.
- R4: In rolling mode the sampled-reset phase is followed by one cycle with `rsp_drive` high, Rw cycles with `rsp_drive` and `px_reset` high, and one more cycle with `rsp_drive` high, and only then by the end cycle. Throughout a frame `rdp_drive` is the inverse of `rsp_drive`.
- R5: In full-frame mode there is no second reset. `rsp_drive` stays low and `rdp_drive` stays high for the whole frame.
- R6: `rdp_sync_n` is low during the first G cycles and the C row-clock cycles of row 0 only. It therefore falls G cycles before `row_clk` rises and rises in the cycle in which `row_clk` falls.
- R7: In rolling mode `rsp_sync_n` has the same timing as R6, but on row index N − `cfg_integ`, or on row 0 when `cfg_integ` is 0. In full-frame mode it never goes low.
- R8: On rows whose index is below `cfg_black`, `px_reset` is also high for the whole first precharge.
- R9: A frame has N = `cfg_rows` rows, with 0 treated as 1. `row_done` is high for the single end cycle of every row, and `frame_done` is high as well in the end cycle of row N − 1. If `run` is high in that cycle, row 0 of a new frame starts in the next cycle. Otherwise the block goes idle.
- R10: All configuration inputs are captured when a frame starts. Changing them during a frame affects only the next frame.
- R11: A programmed width or delay of 0 acts as 1 cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Start frames and keep them going back to back |
| cfg_gap | input | CNT_W (8) | Delay between pulses, in cycles |
| cfg_yclk_w | input | CNT_W (8) | Row clock high width |
| cfg_pc_w | input | CNT_W (8) | Precharge width |
| cfg_sh_w | input | CNT_W (8) | Width of each sample pulse |
| cfg_rst_w | input | CNT_W (8) | Pixel reset width |
| cfg_rows | input | ROW_W (12) | Rows per frame |
| cfg_integ | input | ROW_W (12) | Reset-pointer lead in rows |
| cfg_black | input | ROW_W (12) | Number of leading dark-reference rows |
| cfg_rolling | input | 1 | 1 = rolling shutter, 0 = full frame |
| row_clk | output | 1 | Row pointer clock |
| col_prechg | output | 1 | Column precharge |
| row_sel | output | 1 | Connect selected row to columns |
| samp_sig | output | 1 | Signal-level sample/hold (1 = hold) |
| samp_rst | output | 1 | Reset-level sample/hold (1 = hold) |
| px_reset | output | 1 | Pixel reset of the driven row |
| rdp_drive | output | 1 | Read pointer drives the reset/select lines |
| rsp_drive | output | 1 | Reset pointer drives the reset/select lines |
| rdp_sync_n | output | 1 | Read pointer sync, active low |
| rsp_sync_n | output | 1 | Reset pointer sync, active low |
| row_done | output | 1 | One-cycle end-of-row strobe |
| frame_done | output | 1 | One-cycle end-of-frame strobe |

## Verification
The assertions assume that reset is held low for at least one clock edge. They also assume that `cfg_integ` is smaller than the row count whenever rolling mode is used, because otherwise the reset-pointer sync row has no meaning. Configuration inputs may change at any time, since only the copy taken at frame start is used. The bench changes them in the middle of a frame on purpose. It chooses a lead below the row count in every rolling scenario, and it drives all inputs on the falling clock edge.

// File: rtl/rps_pkg.sv
package rps_pkg;

    parameter int CNT_W = 8;   // width of every cycle-count setting
    parameter int ROW_W = 12;  // width of row indices and row counts

    typedef enum logic [4:0] {
        PH_IDLE, PH_PRE, PH_YCLK, PH_POST, PH_PC1, PH_G1, PH_SELW, PH_SHS,
        PH_SHSH, PH_DESEL, PH_RST1, PH_GR, PH_PC2, PH_GP, PH_SHR,
        PH_SW1, PH_RST2, PH_SW2, PH_END
    } phase_e;

    typedef struct packed {
        logic [CNT_W-1:0] gap;
        logic [CNT_W-1:0] yclk_w;
        logic [CNT_W-1:0] pc_w;
        logic [CNT_W-1:0] sh_w;
        logic [CNT_W-1:0] rst_w;
        logic [ROW_W-1:0] rows;
        logic [ROW_W-1:0] integ;
        logic [ROW_W-1:0] black;
        logic             rolling;
    } cfg_t;

    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
    } eng_t;

    typedef struct packed {
        cfg_t             cfg;
        logic [ROW_W-1:0] row;
    } frm_t;

endpackage

// File: rtl/rps_frame_ctrl.sv
module rps_frame_ctrl
    import rps_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    input  logic row_adv,
    input  cfg_t cfg_in,
    output cfg_t cfg,
    output logic last_row,
    output logic rd_sync_row,
    output logic rs_sync_row,
    output logic black_row
);
    localparam logic [ROW_W-1:0] ROW_ONE = ROW_W'(1);

    frm_t f_d, f_q;
    logic [ROW_W-1:0] rs_row;

    always_comb begin
        f_d = f_q;
        if (frame_start) begin
            f_d.cfg = cfg_in;
            f_d.row = '0;
        end else if (row_adv) begin
            f_d.row = f_q.row + ROW_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    // Row on which the reset pointer is sent back to row 0
    assign rs_row      = (f_q.cfg.integ == '0) ? '0 : (f_q.cfg.rows - f_q.cfg.integ);
    assign cfg         = f_q.cfg;
    assign last_row    = ({1'b0, f_q.row} + {1'b0, ROW_ONE}) >= {1'b0, f_q.cfg.rows};
    assign rd_sync_row = (f_q.row == '0);
    assign rs_sync_row = f_q.cfg.rolling && (f_q.row == rs_row);
    assign black_row   = (f_q.row < f_q.cfg.black);

endmodule

// File: rtl/rps_row_engine.sv
module rps_row_engine
    import rps_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   run,
    input  logic   last_row,
    input  cfg_t   cfg,
    output phase_e phase,
    output logic   frame_start,
    output logic   row_adv
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    eng_t st_d, st_q;
    logic [CNT_W-1:0] dur;
    logic leave;

    // Length of the current phase, taken from the captured settings
    always_comb begin
        case (st_q.ph)
            PH_PRE, PH_POST, PH_G1, PH_SELW, PH_SHSH,
            PH_DESEL, PH_GR, PH_GP:      dur = cfg.gap;
            PH_YCLK:                     dur = cfg.yclk_w;
            PH_PC1, PH_PC2:              dur = cfg.pc_w;
            PH_SHS, PH_SHR:              dur = cfg.sh_w;
            PH_RST1, PH_RST2:            dur = cfg.rst_w;
            default:                     dur = CNT_ONE;
        endcase
    end

    // A zero length still spends one cycle in the phase
    assign leave = ({1'b0, st_q.cnt} + {1'b0, CNT_ONE}) >= {1'b0, dur};

    always_comb begin
        st_d        = st_q;
        frame_start = 1'b0;
        row_adv     = 1'b0;
        if (st_q.ph == PH_IDLE) begin
            st_d.cnt = '0;
            if (run) begin
                st_d.ph     = PH_PRE;
                frame_start = 1'b1;
            end
        end else if (!leave) begin
            st_d.cnt = st_q.cnt + CNT_ONE;
        end else begin
            st_d.cnt = '0;
            case (st_q.ph)
                PH_PRE:   st_d.ph = PH_YCLK;
                PH_YCLK:  st_d.ph = PH_POST;
                PH_POST:  st_d.ph = PH_PC1;
                PH_PC1:   st_d.ph = PH_G1;
                PH_G1:    st_d.ph = PH_SELW;
                PH_SELW:  st_d.ph = PH_SHS;
                PH_SHS:   st_d.ph = PH_SHSH;
                PH_SHSH:  st_d.ph = PH_DESEL;
                PH_DESEL: st_d.ph = PH_RST1;
                PH_RST1:  st_d.ph = PH_GR;
                PH_GR:    st_d.ph = PH_PC2;
                PH_PC2:   st_d.ph = PH_GP;
                PH_GP:    st_d.ph = PH_SHR;
                PH_SHR:   st_d.ph = cfg.rolling ? PH_SW1 : PH_END;
                PH_SW1:   st_d.ph = PH_RST2;
                PH_RST2:  st_d.ph = PH_SW2;
                PH_SW2:   st_d.ph = PH_END;
                PH_END: begin
                    if (!last_row) begin
                        st_d.ph = PH_PRE;
                        row_adv = 1'b1;
                    end else if (run) begin
                        st_d.ph     = PH_PRE;
                        frame_start = 1'b1;
                    end else begin
                        st_d.ph = PH_IDLE;
                    end
                end
                default:  st_d.ph = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{ph: PH_IDLE, cnt: '0};
        else        st_q <= st_d;
    end

    assign phase = st_q.ph;

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_IDLE && !run) |=> (st_q.ph == PH_IDLE)); // R1

endmodule

// File: rtl/rps_pin_decode.sv
module rps_pin_decode
    import rps_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  phase_e phase,
    input  logic   rolling,
    input  logic   last_row,
    input  logic   rd_sync_row,
    input  logic   rs_sync_row,
    input  logic   black_row,
    output logic   row_clk,
    output logic   col_prechg,
    output logic   row_sel,
    output logic   samp_sig,
    output logic   samp_rst,
    output logic   px_reset,
    output logic   rdp_drive,
    output logic   rsp_drive,
    output logic   rdp_sync_n,
    output logic   rsp_sync_n,
    output logic   row_done,
    output logic   frame_done
);
    logic busy, sync_win;

    always_comb begin
        busy       = (phase != PH_IDLE);
        sync_win   = phase inside {PH_PRE, PH_YCLK};
        row_clk    = (phase == PH_YCLK);
        col_prechg = phase inside {PH_PC1, PH_PC2};
        row_sel    = phase inside {PH_SELW, PH_SHS, PH_SHSH};
        samp_sig   = (phase == PH_SHS);
        samp_rst   = (phase == PH_SHR);
        px_reset   = (phase inside {PH_RST1, PH_RST2}) || ((phase == PH_PC1) && black_row);
        rsp_drive  = phase inside {PH_SW1, PH_RST2, PH_SW2};
        rdp_drive  = busy && !rsp_drive;
        rdp_sync_n = !(sync_win && rd_sync_row);
        rsp_sync_n = !(sync_win && rs_sync_row);
        row_done   = (phase == PH_END);
        frame_done = (phase == PH_END) && last_row;
    end

    AST_PC_SEL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(col_prechg && row_sel)); // R2
    AST_SEL_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(row_sel) |-> !$past(col_prechg)); // R2
    AST_SIG_IN_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        samp_sig |-> row_sel); // R3
    AST_RSTSAMP_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
        samp_rst |-> !row_sel); // R3
    AST_DRIVE_COMPL: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (rdp_drive != rsp_drive)); // R4
    AST_DRIVE_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(px_reset) && rsp_drive) |-> $past(rsp_drive)); // R4
    AST_DRIVE_TRAIL: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(px_reset) && $past(rsp_drive)) |-> rsp_drive); // R4
    AST_FULLFRAME_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !rolling |-> !rsp_drive); // R5
    AST_SYNC_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(row_clk) |-> ($stable(rdp_sync_n) && $stable(rsp_sync_n))); // R6
    AST_SYNC_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdp_sync_n) |-> $fell(row_clk)); // R6
    AST_FRAME_IN_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> row_done); // R9

endmodule

// File: rtl/row_pulse_sequencer.sv
module row_pulse_sequencer
    import rps_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] cfg_gap,
    input  logic [CNT_W-1:0] cfg_yclk_w,
    input  logic [CNT_W-1:0] cfg_pc_w,
    input  logic [CNT_W-1:0] cfg_sh_w,
    input  logic [CNT_W-1:0] cfg_rst_w,
    input  logic [ROW_W-1:0] cfg_rows,
    input  logic [ROW_W-1:0] cfg_integ,
    input  logic [ROW_W-1:0] cfg_black,
    input  logic             cfg_rolling,
    output logic             row_clk,
    output logic             col_prechg,
    output logic             row_sel,
    output logic             samp_sig,
    output logic             samp_rst,
    output logic             px_reset,
    output logic             rdp_drive,
    output logic             rsp_drive,
    output logic             rdp_sync_n,
    output logic             rsp_sync_n,
    output logic             row_done,
    output logic             frame_done
);
    cfg_t   cfg_in, cfg;
    phase_e phase;
    logic   frame_start, row_adv, last_row;
    logic   rd_sync_row, rs_sync_row, black_row;

    assign cfg_in = '{gap: cfg_gap, yclk_w: cfg_yclk_w, pc_w: cfg_pc_w,
                      sh_w: cfg_sh_w, rst_w: cfg_rst_w, rows: cfg_rows,
                      integ: cfg_integ, black: cfg_black, rolling: cfg_rolling};

    rps_frame_ctrl u_frame (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .row_adv(row_adv),
        .cfg_in(cfg_in), .cfg(cfg), .last_row(last_row),
        .rd_sync_row(rd_sync_row), .rs_sync_row(rs_sync_row), .black_row(black_row)
    );

    rps_row_engine u_engine (
        .clk(clk), .rst_n(rst_n), .run(run), .last_row(last_row), .cfg(cfg),
        .phase(phase), .frame_start(frame_start), .row_adv(row_adv)
    );

    rps_pin_decode u_decode (
        .clk(clk), .rst_n(rst_n), .phase(phase), .rolling(cfg.rolling),
        .last_row(last_row), .rd_sync_row(rd_sync_row), .rs_sync_row(rs_sync_row),
        .black_row(black_row), .row_clk(row_clk), .col_prechg(col_prechg),
        .row_sel(row_sel), .samp_sig(samp_sig), .samp_rst(samp_rst),
        .px_reset(px_reset), .rdp_drive(rdp_drive), .rsp_drive(rsp_drive),
        .rdp_sync_n(rdp_sync_n), .rsp_sync_n(rsp_sync_n),
        .row_done(row_done), .frame_done(frame_done)
    );

endmodule

// File: tb/tb_row_pulse_sequencer.sv
module tb_row_pulse_sequencer;
    import rps_pkg::*;

    localparam int MAXV = 4096;
    localparam int B_PC = 11, B_SEL = 10, B_SHS = 9, B_SHR = 8, B_RST = 7, B_YCLK = 6;
    localparam int B_SYL = 5, B_SYR = 4, B_RDS = 3, B_RSS = 2, B_RD = 1, B_FD = 0;
    localparam logic [11:0] IDLE_V = 12'h00C;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n, run, cfg_rolling;
    logic [CNT_W-1:0] cfg_gap, cfg_yclk_w, cfg_pc_w, cfg_sh_w, cfg_rst_w;
    logic [ROW_W-1:0] cfg_rows, cfg_integ, cfg_black;
    logic row_clk, col_prechg, row_sel, samp_sig, samp_rst, px_reset;
    logic rdp_drive, rsp_drive, rdp_sync_n, rsp_sync_n, row_done, frame_done;
    logic [11:0] obs;

    row_pulse_sequencer dut (
        .clk(clk), .rst_n(rst_n), .run(run), .cfg_gap(cfg_gap), .cfg_yclk_w(cfg_yclk_w),
        .cfg_pc_w(cfg_pc_w), .cfg_sh_w(cfg_sh_w), .cfg_rst_w(cfg_rst_w),
        .cfg_rows(cfg_rows), .cfg_integ(cfg_integ), .cfg_black(cfg_black),
        .cfg_rolling(cfg_rolling), .row_clk(row_clk), .col_prechg(col_prechg),
        .row_sel(row_sel), .samp_sig(samp_sig), .samp_rst(samp_rst), .px_reset(px_reset),
        .rdp_drive(rdp_drive), .rsp_drive(rsp_drive), .rdp_sync_n(rdp_sync_n),
        .rsp_sync_n(rsp_sync_n), .row_done(row_done), .frame_done(frame_done)
    );

    assign obs = {col_prechg, row_sel, samp_sig, samp_rst, px_reset, row_clk,
                  rdp_drive, rsp_drive, rdp_sync_n, rsp_sync_n, row_done, frame_done};

    int n_tests = 0;
    int n_fail  = 0;
    logic [11:0] exp_q [MAXV];
    int exp_n;
    int rb [64];
    int rb_n;
    int ovl_cnt, sel_gap;
    int nx [9];

    function automatic int mx1(input int v);
        return (v < 1) ? 1 : v;
    endfunction

    task automatic check(input string tag, input bit ok, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic set_cfg(input int g, c, p, s, r, n, integ, black, input bit roll);
        cfg_gap = CNT_W'(g); cfg_yclk_w = CNT_W'(c); cfg_pc_w = CNT_W'(p);
        cfg_sh_w = CNT_W'(s); cfg_rst_w = CNT_W'(r); cfg_rows = ROW_W'(n);
        cfg_integ = ROW_W'(integ); cfg_black = ROW_W'(black); cfg_rolling = roll;
    endtask

    task automatic apply_next();
        set_cfg(nx[0], nx[1], nx[2], nx[3], nx[4], nx[5], nx[6], nx[7], nx[8] != 0);
    endtask

    task automatic clear_exp();
        exp_n = 0; rb_n = 0; rb[0] = 0;
    endtask

    task automatic push(input logic [11:0] v, input int cnt);
        for (int i = 0; i < cnt; i++) begin
            exp_q[exp_n] = v;
            exp_n++;
        end
    endtask

    task automatic close_row();
        rb_n++;
        rb[rb_n] = exp_n;
    endtask

    // Expected waveform of one frame, built from the R3..R8 timeline
    task automatic add_frame(input int g, c, p, s, r, n, integ, black, input bit roll);
        int gg, cc, pp, ss, rr, nn, rsr;
        gg = mx1(g); cc = mx1(c); pp = mx1(p); ss = mx1(s); rr = mx1(r); nn = mx1(n);
        rsr = (integ == 0) ? 0 : nn - integ;
        for (int row = 0; row < nn; row++) begin
            logic [11:0] b, v;
            b = '0; b[B_SYL] = 1'b1; b[B_RDS] = 1'b1; b[B_RSS] = 1'b1;
            v = b;
            if (row == 0) v[B_RDS] = 1'b0;
            if (roll && row == rsr) v[B_RSS] = 1'b0;
            push(v, gg); v[B_YCLK] = 1'b1; push(v, cc);
            push(b, gg);
            v = b; v[B_PC] = 1'b1; if (row < black) v[B_RST] = 1'b1; push(v, pp);
            push(b, gg);
            v = b; v[B_SEL] = 1'b1; push(v, gg);
            v[B_SHS] = 1'b1; push(v, ss); v[B_SHS] = 1'b0; push(v, gg);
            push(b, gg);
            v = b; v[B_RST] = 1'b1; push(v, rr);
            push(b, gg);
            v = b; v[B_PC] = 1'b1; push(v, pp);
            push(b, gg);
            v = b; v[B_SHR] = 1'b1; push(v, ss);
            if (roll) begin
                v = b; v[B_SYL] = 1'b0; v[B_SYR] = 1'b1; push(v, 1);
                v[B_RST] = 1'b1; push(v, rr); v[B_RST] = 1'b0; push(v, 1);
            end
            v = b; v[B_RD] = 1'b1; if (row == nn - 1) v[B_FD] = 1'b1; push(v, 1);
            close_row();
        end
    endtask

    task automatic add_idle();
        push(IDLE_V, 1);
        close_row();
    endtask

    // Raise run, then compare every cycle; one check per expected row
    task automatic play(input string tag, input int stop_at, input int chg_at);
        int last_pc;
        logic prev_sel;
        last_pc = -1; prev_sel = 1'b0; ovl_cnt = 0; sel_gap = -1;
        run = 1'b1;
        for (int k = 0; k < rb_n; k++) begin
            int bad, fc;
            logic [11:0] fa, fe;
            bad = 0; fc = -1; fa = '0; fe = '0;
            for (int t = rb[k]; t < rb[k+1]; t++) begin
                @(negedge clk);
                if (t == stop_at) run = 1'b0;
                if (t == chg_at) apply_next();
                if (obs !== exp_q[t]) begin
                    if (bad == 0) begin fc = t; fa = obs; fe = exp_q[t]; end
                    bad++;
                end
                if (obs[B_PC] && obs[B_SEL]) ovl_cnt++;
                if (obs[B_PC]) last_pc = t;
                if (obs[B_SEL] && !prev_sel && sel_gap < 0) sel_gap = t - last_pc - 1;
                prev_sel = obs[B_SEL];
            end
            n_tests++;
            if (bad != 0) begin
                n_fail++;
                $display("FAIL %s row %0d cycle %0d: got %b expected %b", tag, k, fc, fa, fe);
            end
        end
    endtask

    task automatic test_reset();
        int bad;
        rst_n = 1'b0; run = 1'b0;
        set_cfg(3, 3, 3, 3, 3, 2, 1, 1, 1'b1);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset state", obs === IDLE_V, int'(obs), int'(IDLE_V));
        bad = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (obs !== IDLE_V) bad++;
        end
        check("R1 stays idle while run low", bad == 0, bad, 0);
    endtask

    task automatic test_full_frame();
        set_cfg(2, 3, 2, 2, 3, 3, 1, 0, 1'b0);
        clear_exp(); add_frame(2, 3, 2, 2, 3, 3, 1, 0, 1'b0); add_idle();
        play("R3 R5 R6 R9 full-frame", 0, -1);
        check("R2 full-frame precharge/select overlap", ovl_cnt == 0, ovl_cnt, 0);
        check("R2 full-frame select delay", sel_gap == 2, sel_gap, 2);
    endtask

    task automatic test_rolling();
        set_cfg(1, 2, 3, 1, 2, 4, 1, 0, 1'b1);
        clear_exp(); add_frame(1, 2, 3, 1, 2, 4, 1, 0, 1'b1); add_idle();
        play("R4 R7 rolling", 0, -1);
        check("R2 rolling precharge/select overlap", ovl_cnt == 0, ovl_cnt, 0);
        check("R2 rolling select delay", sel_gap == 1, sel_gap, 1);
    endtask

    task automatic test_black_lead0();
        set_cfg(2, 1, 2, 1, 1, 3, 0, 2, 1'b1);
        clear_exp(); add_frame(2, 1, 2, 1, 1, 3, 0, 2, 1'b1); add_idle();
        play("R7 R8 dark rows, zero lead", 0, -1);
    endtask

    task automatic test_zero_widths();
        set_cfg(0, 0, 0, 0, 0, 2, 0, 0, 1'b1);
        clear_exp(); add_frame(0, 0, 0, 0, 0, 2, 0, 0, 1'b1); add_idle();
        play("R11 zero widths", 0, -1);
    endtask

    task automatic test_back_to_back();
        int len_a;
        set_cfg(1, 1, 1, 1, 1, 2, 1, 0, 1'b1);
        nx = '{2, 2, 1, 2, 2, 2, 0, 1, 0};
        clear_exp();
        add_frame(1, 1, 1, 1, 1, 2, 1, 0, 1'b1);
        len_a = exp_n;
        add_frame(2, 2, 1, 2, 2, 2, 0, 1, 1'b0);
        add_idle();
        play("R9 R10 back-to-back with mid-frame change", len_a + 3, 5);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        test_reset();
        test_full_frame();
        test_rolling();
        test_black_lead0();
        test_zero_widths();
        test_back_to_back();
        repeat (3) @(negedge clk);
        check("R1 idle after last frame", obs === IDLE_V, int'(obs), int'(IDLE_V));
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule